// File: doc/BRIEF.md
# Mesh Element Configuration Command Router

This block is the configuration-time front end of one processing element in a square mesh. Command words arrive from the neighbour to the north and the neighbour to the west. Each word carries a command kind, a target X/Y coordinate pair and a memory location. The element compares the coordinates with its own identity, which is fixed by parameters. A word addressed elsewhere goes out again, unchanged and one register stage later, on the south and east outputs. A word addressed here is consumed.

A consumed write command stores its value into one of the local operand banks or into the control memory. A consumed read command is turned into a response word that keeps the request header and carries the stored value. The response then travels onward like any forwarded word, so that it can leave the array at the far corner. Response words are never acted on; every element passes them through.

All of this happens only while the global compute-enable input is low. While it is high the block is quiet. When both neighbours present a word in the same cycle, the west word is serviced and the north word waits in a single holding register.

Top module: `mcr_node`

## Requirements
- R1: The 56-bit word is laid out from the MSB down as: kind [55:54], X [53:48], Y [47:42], control-select [41], bank [40:39], offset [38:32], value [31:0]. Kind 00 is idle, 01 is write, 10 is read and 11 is response. A word matches when X equals MY_X and Y equals MY_Y.
- R2: After reset both outputs carry the all-zero word.
- R3: A write or read word that does not match, and any response word (matching or not), appears unchanged on both the south and east outputs one cycle after it is serviced. Forwarding such a word leaves the local memories unchanged.
- R4: A matching write with control-select 0 stores value[31:0] at the given offset of the given operand bank (0 to 3). Both outputs carry the all-zero word in the next cycle.
- R5: A matching read with control-select 0 produces, one cycle later on both outputs, a word of kind 11. Bits [53:32] of that word equal those of the request, and bits [31:0] hold the stored operand word.
- R6: With control-select 1, the control entry at the offset is 40 bits wide. A write with bank bit [39]=0 sets its low 32 bits from the value. A write with bank bit [39]=1 sets its upper 8 bits from value[7:0]. A read returns the low 32 bits when bank bit [39]=0, and the upper 8 bits zero-extended when bank bit [39]=1.
- R7: An idle word (kind 00) is never forwarded, whatever its other bits are. A cycle that services nothing gives the all-zero word on both outputs one cycle later.
- R8: When west and north both carry non-idle words and nothing is held, the west word is serviced first. The north word is held and serviced in the next cycle.
- R9: A held word is serviced before any new input. If new words arrive while a word is held, the west word (else the north word) becomes the next held word, and a north word arriving together with a west word at that time is lost.
- R10: While pc_en is high, inputs are ignored, memories do not change and the outputs carry the all-zero word one cycle later. A held word is kept and is serviced once pc_en returns low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_en | input | 1 | Global compute enable; configuration works only while low |
| n_word | input | 56 | Command word from the north neighbour |
| w_word | input | 56 | Command word from the west neighbour |
| s_word | output | 56 | Registered word to the south neighbour |
| e_word | output | 56 | Registered word to the east neighbour |

## Verification
Every operand location and every control entry is written with a value derived arithmetically from its bank and offset, then read back. Writes and reads alternate between the north and west inputs, so that a swapped bank decode, a stuck offset bit or a dead input path produces a mismatch. Write and read words aimed at every other coordinate in a 4x4 window must come out unchanged and must leave memory untouched, which separates the X compare from the Y compare. Timed collisions (two words at once, then two more while one is held) and compute-enable pulses over a pending write and over a held word show the service order, which word is lost, and that the block stays quiet while compute is enabled.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
   typedef enum logic [1:0] {
      K_IDLE  = 2'b00,
      K_PUT   = 2'b01,
      K_LOOK  = 2'b10,
      K_FOUND = 2'b11
   } kind_e;

   localparam int KIND_W = 2;
endpackage

// File: rtl/mcr_ingress.sv
// Two-input service selection with a one-word holding register.
// Priority: held word, then west, then north.
module mcr_ingress #(
   parameter int W = 56
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hold,
   input  logic [W-1:0] w_word,
   input  logic [W-1:0] n_word,
   output logic [W-1:0] pick_word,
   output logic         pick_vld,
   output logic         held_vld
);
   logic         w_v, n_v;
   logic [W-1:0] held_q, held_d;
   logic         held_vq, held_vd;

   assign w_v = |w_word[W-1:W-2];
   assign n_v = |n_word[W-1:W-2];

   always_comb begin
      pick_word = '0;
      pick_vld  = 1'b0;
      held_d    = held_q;
      held_vd   = held_vq;
      if (!hold) begin
         if (held_vq) begin
            pick_word = held_q;
            pick_vld  = 1'b1;
            if (w_v) begin
               held_d  = w_word;
               held_vd = 1'b1;
            end else if (n_v) begin
               held_d  = n_word;
               held_vd = 1'b1;
            end else begin
               held_vd = 1'b0;
            end
         end else if (w_v) begin
            pick_word = w_word;
            pick_vld  = 1'b1;
            if (n_v) begin
               held_d  = n_word;
               held_vd = 1'b1;
            end
         end else if (n_v) begin
            pick_word = n_word;
            pick_vld  = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q  <= '0;
         held_vq <= 1'b0;
      end else begin
         held_q  <= held_d;
         held_vq <= held_vd;
      end
   end

   assign held_vld = held_vq;
endmodule

// File: rtl/mcr_store.sv
// Local operand banks plus control memory, inferred arrays, read combinational.
module mcr_store #(
   parameter int NBANK  = 4,
   parameter int DEPTH  = 128,
   parameter int DATA_W = 32,
   parameter int CTRL_W = 40,
   localparam int BANK_W = $clog2(NBANK),
   localparam int AW     = $clog2(DEPTH),
   localparam int HI_W   = CTRL_W - DATA_W
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic              sel_ctrl,
   input  logic [BANK_W-1:0] bank,
   input  logic [AW-1:0]     ofs,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] bank_rd [NBANK];
   logic [DATA_W-1:0] ctrl_rd;

   generate
      if (NBANK < 2) begin : g_bad_nbank
         $error("mcr_store: NBANK must be at least 2");
      end
      if (HI_W < 0 || HI_W > DATA_W) begin : g_bad_ctrl
         $error("mcr_store: CTRL_W must lie between DATA_W and 2*DATA_W");
      end

      for (genvar b = 0; b < NBANK; b++) begin : g_opd
         logic [DATA_W-1:0] mem [DEPTH];
         always_ff @(posedge clk) begin
            if (wr_en && !sel_ctrl && bank == BANK_W'(b))
               mem[ofs] <= wdata;
         end
         assign bank_rd[b] = mem[ofs];
      end

      if (HI_W > 0) begin : g_ctrl_wide
         logic [CTRL_W-1:0] cmem [DEPTH];
         always_ff @(posedge clk) begin
            if (wr_en && sel_ctrl) begin
               if (bank[0]) cmem[ofs][CTRL_W-1:DATA_W] <= wdata[HI_W-1:0];
               else         cmem[ofs][DATA_W-1:0]      <= wdata;
            end
         end
         assign ctrl_rd = bank[0] ? {{(DATA_W-HI_W){1'b0}}, cmem[ofs][CTRL_W-1:DATA_W]}
                                  : cmem[ofs][DATA_W-1:0];
      end else begin : g_ctrl_flat
         logic [DATA_W-1:0] cmem [DEPTH];
         always_ff @(posedge clk) begin
            if (wr_en && sel_ctrl && !bank[0])
               cmem[ofs] <= wdata;
         end
         assign ctrl_rd = bank[0] ? '0 : cmem[ofs];
      end
   endgenerate

   assign rdata = sel_ctrl ? ctrl_rd : bank_rd[bank];
endmodule

// File: rtl/mcr_node.sv
// Configuration command router of one mesh element.
module mcr_node #(
   parameter int MY_X   = 0,
   parameter int MY_Y   = 0,
   parameter int X_W    = 6,
   parameter int Y_W    = 6,
   parameter int NBANK  = 4,
   parameter int DEPTH  = 128,
   parameter int DATA_W = 32,
   parameter int CTRL_W = 40,
   localparam int BANK_W = $clog2(NBANK),
   localparam int OFS_W  = $clog2(DEPTH),
   localparam int WORD_W = mcr_pkg::KIND_W + X_W + Y_W + 1 + BANK_W + OFS_W + DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pc_en,
   input  logic [WORD_W-1:0] n_word,
   input  logic [WORD_W-1:0] w_word,
   output logic [WORD_W-1:0] s_word,
   output logic [WORD_W-1:0] e_word
);
   import mcr_pkg::*;

   localparam int P_OFS  = DATA_W;
   localparam int P_BANK = P_OFS + OFS_W;
   localparam int P_SEL  = P_BANK + BANK_W;
   localparam int P_Y    = P_SEL + 1;
   localparam int P_X    = P_Y + Y_W;
   localparam int P_KIND = P_X + X_W;

   generate
      if (MY_X < 0 || MY_X >= (1 << X_W)) begin : g_bad_x
         $error("mcr_node: MY_X does not fit in X_W bits");
      end
      if (MY_Y < 0 || MY_Y >= (1 << Y_W)) begin : g_bad_y
         $error("mcr_node: MY_Y does not fit in Y_W bits");
      end
      if ((1 << OFS_W) != DEPTH) begin : g_bad_depth
         $error("mcr_node: DEPTH must be a power of two");
      end
   endgenerate

   logic [WORD_W-1:0] pick_word;
   logic              pick_vld;
   logic              skid_busy;

   mcr_ingress #(.W(WORD_W)) u_ing (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold      (pc_en),
      .w_word    (w_word),
      .n_word    (n_word),
      .pick_word (pick_word),
      .pick_vld  (pick_vld),
      .held_vld  (skid_busy)
   );

   kind_e             kind;
   logic [X_W-1:0]    f_x;
   logic [Y_W-1:0]    f_y;
   logic              f_sel;
   logic [BANK_W-1:0] f_bank;
   logic [OFS_W-1:0]  f_ofs;
   logic [DATA_W-1:0] f_val;
   logic              hit;
   logic              wr_en;
   logic [DATA_W-1:0] rdata;

   assign kind   = kind_e'(pick_word[P_KIND +: KIND_W]);
   assign f_x    = pick_word[P_X +: X_W];
   assign f_y    = pick_word[P_Y +: Y_W];
   assign f_sel  = pick_word[P_SEL];
   assign f_bank = pick_word[P_BANK +: BANK_W];
   assign f_ofs  = pick_word[P_OFS +: OFS_W];
   assign f_val  = pick_word[DATA_W-1:0];
   assign hit    = (f_x == X_W'(MY_X)) && (f_y == Y_W'(MY_Y));
   assign wr_en  = pick_vld && (kind == K_PUT) && hit;

   mcr_store #(
      .NBANK  (NBANK),
      .DEPTH  (DEPTH),
      .DATA_W (DATA_W),
      .CTRL_W (CTRL_W)
   ) u_store (
      .clk      (clk),
      .wr_en    (wr_en),
      .sel_ctrl (f_sel),
      .bank     (f_bank),
      .ofs      (f_ofs),
      .wdata    (f_val),
      .rdata    (rdata)
   );

   logic [WORD_W-1:0] out_d, out_q;

   always_comb begin
      out_d = '0;
      if (pick_vld) begin
         unique case (kind)
            K_FOUND: out_d = pick_word;
            K_PUT:   out_d = hit ? '0 : pick_word;
            K_LOOK:  out_d = hit ? {K_FOUND, pick_word[P_KIND-1:DATA_W], rdata} : pick_word;
            default: out_d = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q <= '0;
      else        out_q <= out_d;
   end

   assign s_word = out_q;
   assign e_word = out_q;
endmodule

// File: rtl/mcr_node_chk.sv
module mcr_node_chk #(
   parameter int MY_X   = 0,
   parameter int MY_Y   = 0,
   parameter int X_W    = 6,
   parameter int Y_W    = 6,
   parameter int DATA_W = 32,
   parameter int WORD_W = 56
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pc_en,
   input logic [WORD_W-1:0] n_word,
   input logic [WORD_W-1:0] w_word,
   input logic [WORD_W-1:0] s_word,
   input logic              skid_busy
);
   localparam int P_KIND = WORD_W - 2;
   localparam int P_X    = P_KIND - X_W;
   localparam int P_Y    = P_X - Y_W;

   logic [1:0] wk, nk, sk;
   logic       w_hit, n_hit, w_v, n_v, lone_w;

   assign wk     = w_word[P_KIND +: 2];
   assign nk     = n_word[P_KIND +: 2];
   assign sk     = s_word[P_KIND +: 2];
   assign w_v    = wk != 2'b00;
   assign n_v    = nk != 2'b00;
   assign w_hit  = (w_word[P_X +: X_W] == X_W'(MY_X)) && (w_word[P_Y +: Y_W] == Y_W'(MY_Y));
   assign n_hit  = (n_word[P_X +: X_W] == X_W'(MY_X)) && (n_word[P_Y +: Y_W] == Y_W'(MY_Y));
   assign lone_w = !pc_en && !skid_busy && w_v;

   // R10: compute enable silences the outputs
   assert_pcen_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pc_en |=> s_word == '0);

   // R3: pass-through of foreign or response words from the west
   assert_forward_west_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (lone_w && (wk == 2'b11 || !w_hit)) |=> s_word == $past(w_word));

   // R3: pass-through from the north when the west is idle
   assert_forward_north_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!pc_en && !skid_busy && !w_v && n_v && (nk == 2'b11 || !n_hit)) |=> s_word == $past(n_word));

   // R4: a matching write is absorbed
   assert_put_absorbed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (lone_w && wk == 2'b01 && w_hit) |=> s_word == '0);

   // R5: a matching read turns into a response with the same header
   assert_read_reply_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (lone_w && wk == 2'b10 && w_hit) |=>
         (sk == 2'b11 && s_word[P_KIND-1:DATA_W] == $past(w_word[P_KIND-1:DATA_W])));

   // R7: nothing to service gives an all-zero word
   assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!pc_en && !skid_busy && !w_v && !n_v) |=> s_word == '0);

   // R8: a collision fills the holding register
   assert_collision_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (lone_w && n_v) |=> skid_busy);
endmodule

bind mcr_node mcr_node_chk #(
   .MY_X   (MY_X),
   .MY_Y   (MY_Y),
   .X_W    (X_W),
   .Y_W    (Y_W),
   .DATA_W (DATA_W),
   .WORD_W (WORD_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pc_en     (pc_en),
   .n_word    (n_word),
   .w_word    (w_word),
   .s_word    (s_word),
   .skid_busy (skid_busy)
);

// File: tb/mcr_node_test.sv
module mcr_node_test;
   localparam int CLK_PERIOD = 10;
   localparam int MX = 1;
   localparam int MY = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pc_en = 1'b0;
   logic [55:0] n_word = '0;
   logic [55:0] w_word = '0;
   logic [55:0] s_word, e_word;

   int n_run = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mcr_node #(.MY_X(MX), .MY_Y(MY)) uut (
      .clk    (clk),
      .rst_n  (rst_n),
      .pc_en  (pc_en),
      .n_word (n_word),
      .w_word (w_word),
      .s_word (s_word),
      .e_word (e_word)
   );

   // R1 field layout
   function automatic logic [55:0] mk(input int k, input int x, input int y,
                                      input int sel, input int b, input int o,
                                      input logic [31:0] v);
      return {2'(k), 6'(x), 6'(y), 1'(sel), 2'(b), 7'(o), v};
   endfunction

   function automatic logic [31:0] opd(input int b, input int o);
      return 32'(b) * 32'h1000_0001 ^ 32'(o) * 32'h0003_0101 ^ 32'h5A5A_0000;
   endfunction

   function automatic logic [7:0] cbyte(input int o);
      return 8'(o) ^ 8'h3C;
   endfunction

   task automatic chk(input logic [55:0] exp, input string req);
      n_run++;
      if (s_word !== exp || e_word !== exp) begin
         n_fail++;
         $display("FAIL %s: south=%h east=%h expected=%h", req, s_word, e_word, exp);
      end
   endtask

   // drive at a falling edge, return at the next falling edge
   task automatic tick(input logic [55:0] w, input logic [55:0] n);
      w_word = w;
      n_word = n;
      @(negedge clk);
      w_word = '0;
      n_word = '0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk('0, "R2 reset");

      // R4: fill all operand banks, alternating input sides
      for (int b = 0; b < 4; b++)
         for (int o = 0; o < 128; o++) begin
            if (o % 2 == 0) tick(mk(1, MX, MY, 0, b, o, opd(b, o)), '0);
            else            tick('0, mk(1, MX, MY, 0, b, o, opd(b, o)));
            chk('0, "R4 write absorbed");
         end

      // R5: read every operand word back
      for (int b = 0; b < 4; b++)
         for (int o = 0; o < 128; o++) begin
            if (o % 2 == 0) tick('0, mk(2, MX, MY, 0, b, o, 32'hFFFF_FFFF));
            else            tick(mk(2, MX, MY, 0, b, o, 32'h0), '0);
            chk(mk(3, MX, MY, 0, b, o, opd(b, o)), "R5 read reply");
         end

      // R6: control memory low word and upper byte
      for (int o = 0; o < 128; o++) begin
         tick(mk(1, MX, MY, 1, 0, o, ~opd(0, o)), '0);
         tick(mk(1, MX, MY, 1, 1, o, {24'hABCDEF, cbyte(o)}), '0);
      end
      for (int o = 0; o < 128; o++) begin
         tick(mk(2, MX, MY, 1, 0, o, 32'h0), '0);
         chk(mk(3, MX, MY, 1, 0, o, ~opd(0, o)), "R6 control low");
         tick('0, mk(2, MX, MY, 1, 1, o, 32'h0));
         chk(mk(3, MX, MY, 1, 1, o, {24'h0, cbyte(o)}), "R6 control upper");
      end

      // R3: foreign coordinates are forwarded, memory untouched
      for (int x = 0; x < 4; x++)
         for (int y = 0; y < 4; y++) begin
            if (x == MX && y == MY) continue;
            tick(mk(1, x, y, 0, 0, x*4+y, 32'hDEAD_0000), '0);
            chk(mk(1, x, y, 0, 0, x*4+y, 32'hDEAD_0000), "R3 foreign write");
            tick('0, mk(2, x, y, 0, 3, x*4+y, 32'h1234_5678));
            chk(mk(2, x, y, 0, 3, x*4+y, 32'h1234_5678), "R3 foreign read");
         end
      for (int o = 0; o < 16; o++) begin
         tick(mk(2, MX, MY, 0, 0, o, 32'h0), '0);
         chk(mk(3, MX, MY, 0, 0, o, opd(0, o)), "R3 memory untouched");
      end
      tick(mk(3, MX, MY, 0, 2, 9, 32'hCAFE_F00D), '0);
      chk(mk(3, MX, MY, 0, 2, 9, 32'hCAFE_F00D), "R3 own response forwarded");

      // R7: idle kind with payload is dropped
      tick(mk(0, MX, MY, 1, 3, 5, 32'hFFFF_FFFF), mk(0, 7, 7, 0, 1, 1, 32'h1));
      chk('0, "R7 idle word");
      tick('0, '0);
      chk('0, "R7 nothing serviced");

      // R8: collision, west first then held north
      tick(mk(2, 0, 0, 0, 0, 1, 32'hA), mk(2, 0, 0, 0, 0, 2, 32'hB));
      chk(mk(2, 0, 0, 0, 0, 1, 32'hA), "R8 west first");
      tick('0, '0);
      chk(mk(2, 0, 0, 0, 0, 2, 32'hB), "R8 north after");
      tick('0, '0);
      chk('0, "R8 drained");

      // R9: held word first, west held next, extra north lost
      tick(mk(1, 3, 3, 0, 0, 1, 32'h11), mk(1, 3, 3, 0, 0, 2, 32'h22));
      chk(mk(1, 3, 3, 0, 0, 1, 32'h11), "R9 first");
      tick(mk(1, 3, 3, 0, 0, 3, 32'h33), mk(1, 3, 3, 0, 0, 4, 32'h44));
      chk(mk(1, 3, 3, 0, 0, 2, 32'h22), "R9 held before new");
      tick('0, '0);
      chk(mk(1, 3, 3, 0, 0, 3, 32'h33), "R9 west held next");
      tick('0, '0);
      chk('0, "R9 north lost");

      // R10: compute enable ignores input and keeps memory
      pc_en = 1'b1;
      tick(mk(1, MX, MY, 0, 1, 3, 32'hDEAD_BEEF), '0);
      chk('0, "R10 write ignored");
      tick('0, mk(2, 5, 5, 0, 0, 0, 32'h5));
      chk('0, "R10 forward suppressed");
      pc_en = 1'b0;
      tick(mk(2, MX, MY, 0, 1, 3, 32'h0), '0);
      chk(mk(3, MX, MY, 0, 1, 3, opd(1, 3)), "R10 memory kept");
      tick(mk(2, 6, 0, 0, 0, 6, 32'h6), mk(2, 0, 6, 0, 0, 7, 32'h7));
      chk(mk(2, 6, 0, 0, 0, 6, 32'h6), "R10 before pause");
      pc_en = 1'b1;
      tick('0, '0);
      chk('0, "R10 paused");
      pc_en = 1'b0;
      tick('0, '0);
      chk(mk(2, 0, 6, 0, 0, 7, 32'h7), "R10 held word kept");

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule